// File: doc/BRIEF.md
# Streaming Fixed-Point Complex Multiplier

This block multiplies a stream of complex samples by a stream of unit phasors and returns the complex product as a third stream. It is the mixing stage of a frequency shifter. An oscillator supplies cosine and sine words on the phasor port. Baseband samples arrive on the sample port. The rotated sample leaves on the product port.

Each input port is a valid/ready slave, and the product port is a valid/ready master. A sample and a phasor are consumed as a pair. Both transfers happen on the same clock edge, and only when both sides are valid and the pipeline can move. The pipeline has four register stages and advances as a single unit. While the product port holds a valid word that is not taken, every stage freezes, and both input readies stay low. Each accepted pair yields exactly one product, in order. The product's end-of-packet flag is copied from the sample stream.

The arithmetic is exact up to one truncation. The sample is signed with 15 fractional bits and the phasor is signed with 14 fractional bits. Each product component is formed at 38 bits. Its six lowest bits are then discarded, which leaves a 32-bit word with 23 fractional bits.

Top module: `cplx_phasor_mult`

## Requirements
- R1: While `rst_n` is low (active-low, synchronous) and on the first cycles after it rises, `m_valid` is 0, and no word is emitted that was not accepted after reset.
- R2: The sample word carries the in-phase part I in bits [23:0] and the quadrature part Q in bits [47:24]. The value of each part is the signed 21-bit number in the low 21 bits of its 24-bit lane, with 15 fractional bits.
- R3: The phasor word carries the cosine in bits [15:0] and the sine in bits [31:16]. Both are signed 16-bit numbers with 14 fractional bits.
- R4: Product bits [31:0] equal bits [37:6] of the exact 38-bit value I·cos − Q·sin. This is the same as floor((I·cos − Q·sin) / 64) in two's complement.
- R5: Product bits [63:32] equal bits [37:6] of the exact 38-bit value I·sin + Q·cos.
- R6: A transfer on either input happens only on an edge where both inputs are valid and the pipeline can advance. The sample ready is never high while the phasor valid is low, and the phasor ready is never high while the sample valid is low. Both ports always see the same number of transfers.
- R7: With `m_ready` held high, the product of a pair transferred on clock edge n is presented with `m_valid` high just after edge n+3. That is four cycles after the cycle in which the pair was offered and accepted.
- R8: While `m_valid` is 1 and `m_ready` is 0, both input readies are 0. On the next cycle, `m_valid`, `m_data` and `m_last` keep their values.
- R9: `m_last` equals the `s_a_last` that was transferred with the same pair. `s_b_last` has no effect on any output.
- R10: Products leave in acceptance order, one per accepted pair. No more than four pairs are ever in flight.
- R11: Bits [23:21] and [47:45] of the sample word have no effect on the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_a_data | input | 48 | Sample word, Q in upper 24 bits and I in lower 24 bits |
| s_a_last | input | 1 | End-of-packet flag of the sample |
| s_a_valid | input | 1 | Sample word offered |
| s_a_ready | output | 1 | Sample word taken on this edge if valid |
| s_b_data | input | 32 | Phasor word, sine in upper 16 bits and cosine in lower 16 bits |
| s_b_last | input | 1 | End-of-packet flag of the phasor (ignored) |
| s_b_valid | input | 1 | Phasor word offered |
| s_b_ready | output | 1 | Phasor word taken on this edge if valid |
| m_data | output | 64 | Product, imaginary part in upper 32 bits and real part in lower 32 bits |
| m_last | output | 1 | End-of-packet flag carried from the sample |
| m_valid | output | 1 | Product word presented |
| m_ready | input | 1 | Downstream accepts the product word |

## Verification
A sweep over every combination of six extreme and ordinary values for I, Q, cosine and sine covers the arithmetic. These values include the most negative numbers, zero, ±1 and full scale. The sweep separates the real and imaginary formulas, the sign handling and the truncation direction, because floor differs from round-toward-zero for negative results. A later random phase adds garbage in the sample's padding bits, which shows that only the low 21 bits of each lane matter. That phase also drives independent sample/phasor valid delays with a randomly stalling sink, so pair joining, stall freezing, ordering and flag routing are tried under back-pressure. A short phase with the sink always ready measures the four-cycle latency exactly.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  // Default lane formats of the multiplier
  localparam int CPM_A_LANE   = 24;  // container width of one sample part
  localparam int CPM_A_BITS   = 21;  // significant bits of one sample part
  localparam int CPM_B_LANE   = 16;  // width of one phasor part
  localparam int CPM_DROP     = 6;   // least significant bits discarded
  localparam int CPM_STAGES   = 4;   // register stages from input to output
  localparam int CPM_NPROD    = 4;   // partial products per complex multiply
endpackage

// File: rtl/cpm_handshake.sv
// Joins the two slave streams and derives the pipeline advance enable.
module cpm_handshake (
  input  logic a_valid,
  input  logic b_valid,
  input  logic out_valid,
  input  logic out_ready,
  output logic a_ready,
  output logic b_ready,
  output logic adv,
  output logic take
);
  always_comb begin
    adv     = !out_valid || out_ready;
    a_ready = adv && b_valid;
    b_ready = adv && a_valid;
    take    = adv && a_valid && b_valid;
  end
endmodule

// File: rtl/cpm_prod_stage.sv
// Registers the four full-precision partial products.
// Index map: 0 = I*cos, 1 = Q*cos, 2 = I*sin, 3 = Q*sin
module cpm_prod_stage #(
  parameter int A_BITS = cpm_pkg::CPM_A_BITS,
  parameter int B_W    = cpm_pkg::CPM_B_LANE,
  localparam int P_W   = A_BITS + B_W
) (
  input  logic                clk,
  input  logic                en,
  input  logic signed [A_BITS-1:0] s_i,
  input  logic signed [A_BITS-1:0] s_q,
  input  logic signed [B_W-1:0]    p_c,
  input  logic signed [B_W-1:0]    p_s,
  output logic signed [P_W-1:0]    prod [cpm_pkg::CPM_NPROD]
);
  for (genvar k = 0; k < cpm_pkg::CPM_NPROD; k++) begin : g_term
    logic signed [A_BITS-1:0] samp;
    logic signed [B_W-1:0]    ph;
    logic signed [P_W-1:0]    term_q;

    assign samp = (k % 2 == 1) ? s_q : s_i;
    assign ph   = (k >= 2)     ? p_s : p_c;

    always_ff @(posedge clk) begin
      if (en) term_q <= P_W'(samp) * P_W'(ph);
    end

    assign prod[k] = term_q;
  end
endmodule

// File: rtl/cpm_combine.sv
// Forms the exact real/imaginary sums, then drops the low bits.
module cpm_combine #(
  parameter int A_BITS = cpm_pkg::CPM_A_BITS,
  parameter int B_W    = cpm_pkg::CPM_B_LANE,
  parameter int DROP   = cpm_pkg::CPM_DROP,
  localparam int P_W   = A_BITS + B_W,
  localparam int FULL_W = P_W + 1,
  localparam int OUT_W = FULL_W - DROP
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [P_W-1:0]   prod [cpm_pkg::CPM_NPROD],
  output logic [OUT_W-1:0]        re_o,
  output logic [OUT_W-1:0]        im_o
);
  logic signed [FULL_W-1:0] re_full, im_full;
  logic signed [FULL_W-1:0] ic_x, qc_x, is_x, qs_x;

  always_comb begin
    ic_x = FULL_W'(prod[0]);
    qc_x = FULL_W'(prod[1]);
    is_x = FULL_W'(prod[2]);
    qs_x = FULL_W'(prod[3]);
  end

  always_ff @(posedge clk) begin
    if (en) begin
      re_full <= ic_x - qs_x;
      im_full <= is_x + qc_x;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      re_o <= re_full[FULL_W-1:DROP];
      im_o <= im_full[FULL_W-1:DROP];
    end
  end
endmodule

// File: rtl/cplx_phasor_mult.sv
// Four-stage streaming complex multiplier: sample times phasor.
module cplx_phasor_mult #(
  parameter int A_W    = cpm_pkg::CPM_A_LANE,
  parameter int A_BITS = cpm_pkg::CPM_A_BITS,
  parameter int B_W    = cpm_pkg::CPM_B_LANE,
  parameter int DROP   = cpm_pkg::CPM_DROP,
  localparam int OUT_W = A_BITS + B_W + 1 - DROP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*A_W-1:0]   s_a_data,
  input  logic               s_a_last,
  input  logic               s_a_valid,
  output logic               s_a_ready,
  input  logic [2*B_W-1:0]   s_b_data,
  input  logic               s_b_last,
  input  logic               s_b_valid,
  output logic               s_b_ready,
  output logic [2*OUT_W-1:0] m_data,
  output logic               m_last,
  output logic               m_valid,
  input  logic               m_ready
);
  localparam int STAGES = cpm_pkg::CPM_STAGES;
  localparam int P_W    = A_BITS + B_W;

  logic adv, take;
  logic [STAGES-1:0] vld, lst;

  cpm_handshake u_hs (
    .a_valid  (s_a_valid),
    .b_valid  (s_b_valid),
    .out_valid(vld[STAGES-1]),
    .out_ready(m_ready),
    .a_ready  (s_a_ready),
    .b_ready  (s_b_ready),
    .adv      (adv),
    .take     (take)
  );

  // Stage 1: capture the significant bits of each operand
  logic signed [A_BITS-1:0] i1, q1;
  logic signed [B_W-1:0]    c1, s1;

  always_ff @(posedge clk) begin
    if (adv) begin
      i1 <= s_a_data[A_BITS-1:0];
      q1 <= s_a_data[A_W+A_BITS-1:A_W];
      c1 <= s_b_data[B_W-1:0];
      s1 <= s_b_data[2*B_W-1:B_W];
    end
  end

  // Valid and last flags travel alongside the data
  for (genvar g = 0; g < STAGES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) vld[g] <= 1'b0;
      else if (adv) vld[g] <= (g == 0) ? take : vld[(g == 0) ? 0 : g-1];
    end
    always_ff @(posedge clk) begin
      if (adv) lst[g] <= (g == 0) ? s_a_last : lst[(g == 0) ? 0 : g-1];
    end
  end

  // Stage 2: partial products
  logic signed [P_W-1:0] prod [cpm_pkg::CPM_NPROD];

  cpm_prod_stage #(.A_BITS(A_BITS), .B_W(B_W)) u_prod (
    .clk (clk),
    .en  (adv),
    .s_i (i1),
    .s_q (q1),
    .p_c (c1),
    .p_s (s1),
    .prod(prod)
  );

  // Stages 3 and 4: exact sums, then truncation
  logic [OUT_W-1:0] re_o, im_o;

  cpm_combine #(.A_BITS(A_BITS), .B_W(B_W), .DROP(DROP)) u_comb (
    .clk (clk),
    .en  (adv),
    .prod(prod),
    .re_o(re_o),
    .im_o(im_o)
  );

  assign m_data  = {im_o, re_o};
  assign m_valid = vld[STAGES-1];
  assign m_last  = lst[STAGES-1];
endmodule

// File: rtl/cpm_chk.sv
// Protocol checker, attached to the multiplier with bind.
module cpm_chk #(
  parameter int D_W = 64,
  parameter int DEPTH = cpm_pkg::CPM_STAGES
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_a_valid,
  input logic           s_a_ready,
  input logic           s_b_valid,
  input logic           s_b_ready,
  input logic [D_W-1:0] m_data,
  input logic           m_last,
  input logic           m_valid,
  input logic           m_ready
);
  logic a_fire, b_fire, o_fire;
  logic [7:0] inflight;

  assign a_fire = s_a_valid && s_a_ready;
  assign b_fire = s_b_valid && s_b_ready;
  assign o_fire = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(a_fire) - 8'(o_fire);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_valid);

  // R6
  paired_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_fire == b_fire);

  // R6
  ready_needs_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_a_ready |-> s_b_valid) and (s_b_ready |-> s_a_valid));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> (!s_a_ready && !s_b_ready));

  // R8
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R10
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(DEPTH));

  // R10
  no_phantom_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> inflight != 8'd0);
endmodule

bind cplx_phasor_mult cpm_chk #(.D_W(2*OUT_W)) u_cpm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_a_valid(s_a_valid),
  .s_a_ready(s_a_ready),
  .s_b_valid(s_b_valid),
  .s_b_ready(s_b_ready),
  .m_data   (m_data),
  .m_last   (m_last),
  .m_valid  (m_valid),
  .m_ready  (m_ready)
);

// File: tb/cplx_phasor_mult_test.sv
module cplx_phasor_mult_test;
  localparam int AW = 24, AB = 21, BW = 16, DR = 6, OW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [2*AW-1:0] s_a_data = '0;
  logic            s_a_last = 1'b0, s_a_valid = 1'b0, s_a_ready;
  logic [2*BW-1:0] s_b_data = '0;
  logic            s_b_last = 1'b0, s_b_valid = 1'b0, s_b_ready;
  logic [2*OW-1:0] m_data;
  logic            m_last, m_valid;
  logic            m_ready = 1'b0;

  cplx_phasor_mult uut (
    .clk(clk), .rst_n(rst_n),
    .s_a_data(s_a_data), .s_a_last(s_a_last), .s_a_valid(s_a_valid), .s_a_ready(s_a_ready),
    .s_b_data(s_b_data), .s_b_last(s_b_last), .s_b_valid(s_b_valid), .s_b_ready(s_b_ready),
    .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready)
  );

  int nchk = 0, nfail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  typedef struct {
    logic [OW-1:0] re;
    logic [OW-1:0] im;
    logic          last;
    bit            pad;
    longint        t;
  } exp_t;
  exp_t exq[$];

  bit lat_mode = 0;
  int sink_mode = 0;
  int n_a = 0, n_b = 0, n_out = 0;
  bit prev_stall = 0;
  logic [2*OW-1:0] prev_data;
  logic prev_last;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic exp_t model(input logic [2*AW-1:0] a, input logic [2*BW-1:0] b,
                                 input logic la);
    exp_t e;
    longint i, q, c, s, re, im;
    i  = sx(longint'(a[AB-1:0]), AB);
    q  = sx(longint'(a[AW+AB-1:AW]), AB);
    c  = sx(longint'(b[BW-1:0]), BW);
    s  = sx(longint'(b[2*BW-1:BW]), BW);
    re = i * c - q * s;
    im = i * s + q * c;
    e.re   = OW'(re >>> DR);
    e.im   = OW'(im >>> DR);
    e.last = la;
    e.pad  = (a[AW-1:AB] != a[AB-1] * 3'b111) || (a[2*AW-1:AW+AB] != a[AW+AB-1] * 3'b111);
    e.t    = cyc;
    return e;
  endfunction

  // Monitor: samples mid-cycle, inputs change just after rising edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (s_a_valid && s_a_ready) begin
        n_a++;
        exq.push_back(model(s_a_data, s_b_data, s_a_last));
      end
      if (s_b_valid && s_b_ready) n_b++;
      if (prev_stall) begin
        // R8: held product
        chk(m_valid && m_data == prev_data && m_last == prev_last, "R8 hold",
            longint'(m_data[31:0]), longint'(prev_data[31:0]));
      end
      if (m_valid && !m_ready)
        chk(!s_a_ready && !s_b_ready, "R8 ready low", {s_a_ready, s_b_ready}, 0);
      if (m_valid && m_ready) begin
        n_out++;
        if (exq.size() == 0) chk(0, "R10 unexpected output", 1, 0);
        else begin
          exp_t e;
          e = exq.pop_front();
          chk(m_data[OW-1:0] == e.re, e.pad ? "R11 real" : "R4 real (R2 R3)",
              longint'(m_data[OW-1:0]), longint'(e.re));
          chk(m_data[2*OW-1:OW] == e.im, e.pad ? "R11 imag" : "R5 imag",
              longint'(m_data[2*OW-1:OW]), longint'(e.im));
          chk(m_last == e.last, "R9 last", longint'(m_last), longint'(e.last));
          if (lat_mode) chk(cyc - e.t == 4, "R7 latency", cyc - e.t, 4);
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
      prev_last  = m_last;
    end
  end

  // Sink
  initial forever begin
    @(posedge clk); #1;
    if (!rst_n) m_ready = 1'b0;
    else if (sink_mode == 0) m_ready = 1'b1;
    else m_ready = ($urandom % 100) < 60;
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [2*AW-1:0] a, input logic [2*BW-1:0] b,
                      input bit la, input bit lb, input int da, input int db);
    int k = 0;
    bit fired = 0;
    while (!fired) begin
      if (k >= da) begin s_a_valid = 1'b1; s_a_data = a; s_a_last = la; end
      if (k >= db) begin s_b_valid = 1'b1; s_b_data = b; s_b_last = lb; end
      @(negedge clk);
      // R6: a lone valid side must not see ready
      if (s_a_valid && !s_b_valid) chk(!s_a_ready, "R6 lone sample", s_a_ready, 0);
      if (s_b_valid && !s_a_valid) chk(!s_b_ready, "R6 lone phasor", s_b_ready, 0);
      fired = s_a_valid && s_a_ready && s_b_valid;
      @(posedge clk); #1;
      k++;
    end
    s_a_valid = 1'b0;
    s_b_valid = 1'b0;
  endtask

  function automatic logic [2*AW-1:0] mk_a(input longint i, input longint q, input bit junk);
    logic [AW-1:0] li, lq;
    li = AW'(i);
    lq = AW'(q);
    if (junk) begin
      li[AW-1:AB] = 3'($urandom);
      lq[AW-1:AB] = 3'($urandom);
    end
    return {lq, li};
  endfunction

  longint ca[6] = '{-1048576, -1, 0, 1, 1048575, -349525};
  longint cb[6] = '{-32768, -1, 0, 1, 32767, 23170};

  initial begin
    // R1: reset state
    repeat (5) begin
      @(negedge clk);
      chk(!m_valid, "R1 in reset", m_valid, 0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!m_valid, "R1 after reset", m_valid, 0);
    end
    @(posedge clk); #1;

    // Latency phase: sink always ready
    sink_mode = 0;
    lat_mode = 1;
    send(mk_a(1000, -2000, 0), {16'sd8192, 16'sd16384}, 1, 0, 0, 0);
    idle(6);
    send(mk_a(-5, 7, 0), {16'sd300, -16'sd300}, 0, 1, 0, 0);   // R9 flags differ
    send(mk_a(123456, -654321, 0), {-16'sd1, 16'sd32767}, 1, 1, 0, 2);
    send(mk_a(-1048576, 1048575, 0), {-16'sd32768, -16'sd32768}, 0, 0, 3, 0);
    for (int n = 0; n < 30; n++)
      send(mk_a(sx($urandom, AB), sx($urandom, AB), 0), 32'($urandom),
           1'($urandom), 1'($urandom), 0, 0);
    idle(10);
    lat_mode = 0;

    // Corner sweep under random back-pressure
    sink_mode = 1;
    for (int ii = 0; ii < 6; ii++)
      for (int qq = 0; qq < 6; qq++)
        for (int cc = 0; cc < 6; cc++)
          for (int ss = 0; ss < 6; ss++)
            send(mk_a(ca[ii], ca[qq], 0), {BW'(cb[ss]), BW'(cb[cc])},
                 1'($urandom), 1'($urandom), 0, 0);

    // Random values, padding garbage, independent valid delays
    for (int n = 0; n < 1500; n++) begin
      idle($urandom % 3);
      send(mk_a(sx($urandom, AB), sx($urandom, AB), 1'($urandom)), 32'($urandom),
           1'($urandom), 1'($urandom), $urandom % 3, $urandom % 3);
    end
    idle(60);

    // R10 / R6: everything accounted for
    chk(exq.size() == 0, "R10 drained", exq.size(), 0);
    chk(n_out == n_a, "R10 one per pair", n_out, n_a);
    chk(n_a == n_b, "R6 equal transfers", n_a, n_b);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", n_out, n_a);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule